// File: doc/BRIEF.md
# Peripheral clock-stop controller

The block lets software stop and restart the clock of individual peripheral groups through a two-address, 32-bit register port. Group 1 feeds timer channels 3 and 4. Group 0 feeds the interrupt controller logic that watches those timer channels. The stop register can only be set through its own address. A separate write-one-to-clear address releases stop bits, so software never needs a read-modify-write sequence to change one group.

Each group has a small two-state machine. In state `PCS_RUN` the group is clocked. In state `PCS_STOP` its clock is held off. The transition `SET_REQ` (a 1 written at the set address) moves the machine from `PCS_RUN` to `PCS_STOP`. The transition `CLR_REQ` (a 1 written at the clear address) moves it from `PCS_STOP` to `PCS_RUN`. When both requests are present for one bit, `CLR_REQ` has priority. With no request, each state holds.

Each group drives a clock-enable output and a latch-based clock gate model. The gate captures its enable only while the clock is low, so the gated clock never produces a shortened pulse. Stopping group 0 also drops an interrupt-detect enable. Only the power-on reset clears the stop bits. A manual reset and standby both leave them untouched.

Top module: `pclk_stop_ctrl`

## Requirements
- R1: While `por_n` is low and after it is released, both stop bits are 0. The outputs are then `grp_clk_en` = 2'b11, `irq_det_en` = 1 and `rdata` = 0.
- R2: A write (`wr_en`=1) to address 0x00 with `wdata[g]`=1 sets stop bit g. `grp_clk_en[g]` goes to 0 right after the rising edge that samples the write.
- R3: Writing 0 to a bit at address 0x00 leaves that stop bit unchanged.
- R4: A write to address 0x04 with `wdata[g]`=1 clears stop bit g, and `grp_clk_en[g]` returns to 1 after that edge. A 0 in a bit at 0x04 has no effect, and neither does a write to any other address.
- R5: A read (`rd_en`=1) is registered. After the sampling edge, `rdata` holds the value at the addressed location and keeps it until the next read. Address 0x00 returns the stop bits in bits [1:0]. Address 0x04 returns 0.
- R6: Bits 31 to 2 of the stop register always read 0, and writes to those bits are ignored.
- R7: A low `mrst_n` leaves the stop bits unchanged and clears `rdata` to 0 at the next edge.
- R8: While `standby` is high, the stop bits keep their value and `rdata` is held at 0.
- R9: Bit 1 is the timer channels 3/4 group and bit 0 is the interrupt-controller group. Whenever stop bit g is 1, `grp_clk_en[g]` is 0 and `gclk[g]` stays low. `irq_det_en` is 0 exactly when stop bit 0 is 1.
- R10: `gclk[g]` is `clk` gated by an enable captured while `clk` is low. A change that happens at a rising edge first affects the next clock pulse, and the pulse already in progress completes at full width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral bus clock, also the clock being gated |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mrst_n | input | 1 | Manual reset, active low, synchronous |
| standby | input | 1 | Standby indication, high while in standby |
| addr | input | 8 | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| grp_clk_en | output | 2 | Per-group clock enable, 1 = clock runs |
| gclk | output | 2 | Per-group gated clock |
| irq_det_en | output | 1 | Interrupt-detect enable for timer channels 3 and 4 |

## Verification
The bench walks the stop bits through set, clear, zero-valued and all-ones writes, and through writes to an unmapped address. This separates a true set-only and clear-only register from a plain write register, and shows whether the reserved bits are masked. Manual reset and standby are applied with both groups stopped, so any reset leaking into the stop bits shows up at the enables and on the following read. The gated clocks are sampled mid-pulse in the cycle of a change and in the cycle after it. This tells a latched, glitch-free gate apart from an ungated combinational one.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    localparam int PCS_DATA_W   = 32;
    localparam int PCS_GRP_INTC = 0;
    localparam int PCS_GRP_TMU  = 1;

    typedef enum logic {
        PCS_RUN  = 1'b0,
        PCS_STOP = 1'b1
    } pcs_state_e;
endpackage

// File: rtl/pcs_stop_fsm.sv
module pcs_stop_fsm
    import pcs_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic set_req,
    input  logic clr_req,
    output logic stopped
);
    pcs_state_e state_q, state_d;

    // only power-on reset touches the stop state
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) state_q <= PCS_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PCS_RUN:  if (set_req && !clr_req) state_d = PCS_STOP;
            PCS_STOP: if (clr_req)             state_d = PCS_RUN;
            default:  state_d = PCS_RUN;
        endcase
    end

    always_comb begin
        stopped = (state_q == PCS_STOP);
    end
endmodule

// File: rtl/pcs_clk_gate.sv
module pcs_clk_gate (
    input  logic clk,
    input  logic en,
    output logic gclk
);
    logic en_lat;

    // transparent while clk is low, holds through the high phase
    always_latch begin
        if (!clk) en_lat = en;
    end

    assign gclk = clk & en_lat;
endmodule

// File: rtl/pclk_stop_ctrl.sv
module pclk_stop_ctrl
    import pcs_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter int                DATA_W  = PCS_DATA_W,
    parameter int                N_GRP   = 2,
    parameter logic [ADDR_W-1:0] SET_OFS = 8'h00,
    parameter logic [ADDR_W-1:0] CLR_OFS = 8'h04
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              mrst_n,
    input  logic              standby,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [N_GRP-1:0]  grp_clk_en,
    output logic [N_GRP-1:0]  gclk,
    output logic              irq_det_en
);
    logic              hit_set, hit_clr;
    logic [N_GRP-1:0]  stop_q;
    logic [DATA_W-1:0] rd_next, rd_q;
    logic              unused_wdata;

    assign hit_set      = wr_en && (addr == SET_OFS);
    assign hit_clr      = wr_en && (addr == CLR_OFS);
    assign unused_wdata = ^wdata[DATA_W-1:N_GRP];

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        pcs_stop_fsm u_fsm (
            .clk     (clk),
            .por_n   (por_n),
            .set_req (hit_set && wdata[g]),
            .clr_req (hit_clr && wdata[g]),
            .stopped (stop_q[g])
        );
        pcs_clk_gate u_cg (
            .clk  (clk),
            .en   (!stop_q[g]),
            .gclk (gclk[g])
        );
    end

    assign grp_clk_en = ~stop_q;
    assign irq_det_en = !stop_q[PCS_GRP_INTC];

    always_comb begin
        rd_next = '0;
        if (addr == SET_OFS) rd_next[N_GRP-1:0] = stop_q;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)                 rd_q <= '0;
        else if (!mrst_n || standby) rd_q <= '0;
        else if (rd_en)             rd_q <= rd_next;
    end

    assign rdata = rd_q;
endmodule

// File: rtl/pcs_chk.sv
module pcs_chk
    import pcs_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter int                DATA_W  = PCS_DATA_W,
    parameter int                N_GRP   = 2,
    parameter logic [ADDR_W-1:0] SET_OFS = 8'h00,
    parameter logic [ADDR_W-1:0] CLR_OFS = 8'h04
) (
    input logic              clk,
    input logic              por_n,
    input logic              mrst_n,
    input logic              standby,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [N_GRP-1:0]  grp_clk_en,
    input logic [N_GRP-1:0]  gclk,
    input logic              irq_det_en
);
    logic unused_chk;
    assign unused_chk = rd_en ^ (^gclk);

    for (genvar g = 0; g < N_GRP; g++) begin : g_a
        p_set_r2: assert property (@(posedge clk) disable iff (!por_n)
            (wr_en && addr == SET_OFS && wdata[g]) |=> !grp_clk_en[g]);
        p_clr_r4: assert property (@(posedge clk) disable iff (!por_n)
            (wr_en && addr == CLR_OFS && wdata[g]) |=> grp_clk_en[g]);
        // covers R3, R7 and R8: without a 1 at either address nothing moves
        p_hold_r3: assert property (@(posedge clk) disable iff (!por_n)
            !(wr_en && (addr == SET_OFS || addr == CLR_OFS) && wdata[g])
            |=> $stable(grp_clk_en[g]));
    end

    p_irq_r9: assert property (@(posedge clk) disable iff (!por_n)
        !grp_clk_en[PCS_GRP_INTC] |-> !irq_det_en);
    p_rdhi_r6: assert property (@(posedge clk) disable iff (!por_n)
        rdata[DATA_W-1:N_GRP] == '0);
    p_mrst_r7: assert property (@(posedge clk) disable iff (!por_n)
        !mrst_n |=> rdata == '0);
    p_stby_r8: assert property (@(posedge clk) disable iff (!por_n)
        standby |=> rdata == '0);
endmodule

bind pclk_stop_ctrl pcs_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_GRP(N_GRP),
    .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS)
) u_chk (.*);

// File: tb/sim_pclk_stop_ctrl.sv
`timescale 1ns/1ps
module sim_pclk_stop_ctrl;
    localparam int PER = 10;

    logic        clk = 1'b0;
    logic        por_n, mrst_n, standby, wr_en, rd_en;
    logic [7:0]  addr;
    logic [31:0] wdata, rdata;
    logic [1:0]  grp_clk_en, gclk;
    logic        irq_det_en;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(PER/2) clk = ~clk;

    pclk_stop_ctrl u0 (
        .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .standby(standby),
        .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
        .rdata(rdata), .grp_clk_en(grp_clk_en), .gclk(gclk),
        .irq_det_en(irq_det_en)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(logic [7:0] a, logic [31:0] exp, string tag);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // monitor: compare registered read data against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                #(PER/4);
                if (exp_q.size() == 0) begin
                    check("R5 unexpected read", 32'h1, 32'h0);
                end else begin
                    check(tag_q.pop_front(), rdata, exp_q.pop_front());
                end
            end
        end
    end

    task automatic finish_run();
        check("R5 scoreboard drained", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(PER * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        por_n = 1'b0; mrst_n = 1'b1; standby = 1'b0;
        wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
        check("R1 clk_en after por", {30'd0, grp_clk_en}, 32'h3);
        check("R1 irq_det_en after por", {31'd0, irq_det_en}, 32'h1);
        check("R1 rdata after por", rdata, 32'h0);
        bus_read(8'h00, 32'h0, "R5 read set reg idle");

        bus_write(8'h00, 32'h2);
        check("R2 set tmu bit", {30'd0, grp_clk_en}, 32'h1);
        check("R9 irq kept with tmu stop", {31'd0, irq_det_en}, 32'h1);
        bus_read(8'h00, 32'h2, "R5 read tmu stopped");
        @(posedge clk); #(PER/4);
        check("R9 gclk tmu held low, intc runs", {30'd0, gclk}, 32'h1);

        bus_write(8'h00, 32'h0);
        check("R3 zero write keeps bits", {30'd0, grp_clk_en}, 32'h1);

        bus_write(8'h00, 32'hFFFF_FFFD);
        check("R2 set intc bit", {30'd0, grp_clk_en}, 32'h0);
        check("R9 irq detect off", {31'd0, irq_det_en}, 32'h0);
        bus_read(8'h00, 32'h3, "R6 upper bits read zero");

        bus_write(8'h04, 32'hFFFF_FFFC);
        check("R4 zero bits at clear no effect", {30'd0, grp_clk_en}, 32'h0);
        bus_write(8'h08, 32'hFFFF_FFFF);
        check("R4 unmapped write no effect", {30'd0, grp_clk_en}, 32'h0);
        bus_write(8'h04, 32'h1);
        check("R4 clear intc bit", {30'd0, grp_clk_en}, 32'h1);
        check("R9 irq detect back on", {31'd0, irq_det_en}, 32'h1);
        bus_read(8'h04, 32'h0, "R5 clear reg reads zero");

        // R10: stop intc group, change at edge k; pulse k full, k+1 gated
        @(negedge clk);
        addr = 8'h00; wdata = 32'h1; wr_en = 1'b1;
        @(posedge clk); #(PER/4);
        check("R10 pulse in change cycle complete", {31'd0, gclk[0]}, 32'h1);
        @(negedge clk); wr_en = 1'b0;
        @(posedge clk); #(PER/4);
        check("R10 next pulse gated", {31'd0, gclk[0]}, 32'h0);
        @(negedge clk);
        addr = 8'h04; wdata = 32'h1; wr_en = 1'b1;
        @(posedge clk); #(PER/4);
        check("R10 no runt on release", {31'd0, gclk[0]}, 32'h0);
        @(negedge clk); wr_en = 1'b0;
        @(posedge clk); #(PER/4);
        check("R10 pulse after release", {31'd0, gclk[0]}, 32'h1);

        bus_write(8'h00, 32'h3);
        bus_read(8'h00, 32'h3, "R5 both stopped");
        @(negedge clk); mrst_n = 1'b0;
        @(negedge clk); mrst_n = 1'b1;
        check("R7 manual reset clears rdata", rdata, 32'h0);
        check("R7 manual reset keeps bits", {30'd0, grp_clk_en}, 32'h0);
        bus_read(8'h00, 32'h3, "R7 bits read after manual reset");

        @(negedge clk); standby = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 rdata held zero in standby", rdata, 32'h0);
        check("R8 standby keeps bits", {30'd0, grp_clk_en}, 32'h0);
        standby = 1'b0;
        bus_read(8'h00, 32'h3, "R8 bits read after standby");

        @(negedge clk); por_n = 1'b0;
        @(negedge clk); por_n = 1'b1;
        @(negedge clk);
        check("R1 por clears stop bits", {30'd0, grp_clk_en}, 32'h3);
        bus_read(8'h00, 32'h0, "R1 read after second por");

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule